// File: doc/BRIEF.md
# Alternate Horizontal Sweep Selector

This block decides which of two timebases, the main sweep or the delayed sweep, is routed to the horizontal amplifier of a dual-timebase display. A two-bit mode input picks one of three modes. Main-only pins the selection to the main sweep. Delayed-only pins it to the delayed sweep. Alternate mode flips the selection once per display pass, so that both traces are shown one after the other.

In alternate mode the flip is normally caused by a falling edge of the alt-sync strobe. When the vertical section is itself alternating between channels, the flip is caused instead by a falling edge of the channel-1-selected square wave. That wave changes state at the end of each main sweep, so the two horizontal traces line up with the vertical channel switching.

Both strobes are asynchronous. They pass through a synchroniser, and their edges are detected inside the clock domain. An active-low separation enable is produced alongside the select bit, so that the analog circuitry can offset the delayed trace vertically.

Top module: `alt_sweep_selector`

## Requirements
- R1: With `hmode` = 2'b00 (main only), or the unused code 2'b11, `dly_sel` is 0 from the clock edge that samples the mode, and `sep_n` is 1.
- R2: With `hmode` = 2'b01 (delayed only), `dly_sel` is 1 from the clock edge that samples the mode, and `sep_n` is 1.
- R3: In alternate mode (`hmode` = 2'b10) with `vert_alt` low, each falling edge of `alt_sync` inverts `dly_sel` exactly once. Rising edges of `alt_sync` and any activity on `ch1_sel` leave it unchanged.
- R4: In alternate mode with `vert_alt` high, each falling edge of `ch1_sel` (a rising edge of its inverse) inverts `dly_sel` exactly once. `alt_sync` edges and rising edges of `ch1_sel` leave it unchanged.
- R5: Entering alternate mode from any other mode sets `dly_sel` to 0 (main sweep) on the first clock edge that samples 2'b10.
- R6: `sep_n` is 0 exactly when `dly_sel` is 1 and the block has been in alternate mode since the previous edge. Otherwise it is 1, and it updates on the same edge as `dly_sel`.
- R7: While the synchronous active-high `rst` is sampled high, the next edge sets `dly_sel` to 0 and `sep_n` to 1.
- R8: With the default of two synchroniser stages, an input fall placed before clock edge k changes `dly_sel` at edge k+2 and not earlier. Each detected edge is a pulse one cycle long.
- R9: In main-only and delayed-only modes, strobe edges have no effect on `dly_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hmode | input | 2 | Horizontal mode: 00 main, 01 delayed, 10 alternate, 11 main |
| vert_alt | input | 1 | High when the vertical section alternates channels (synchronous level) |
| alt_sync | input | 1 | Alt-sync strobe, asynchronous |
| ch1_sel | input | 1 | Channel-1-selected square wave, asynchronous |
| dly_sel | output | 1 | 1 = delayed sweep shown, 0 = main sweep shown |
| sep_n | output | 1 | Active-low trace separation enable |

## Verification
The assertions assume that `hmode` and `vert_alt` are synchronous levels. They also assume that a strobe edge is never in the synchroniser at the moment the mode or the toggle source changes, so that each detected pulse belongs to one well-defined configuration. The stimulus follows these rules by holding every strobe level for several cycles and waiting for the pipeline to drain before it changes the mode or `vert_alt`. Within those limits, the random choice of operation, mode and order is free.

// File: rtl/alt_sweep_pkg.sv
package alt_sweep_pkg;

  typedef enum logic [1:0] {
    HM_MAIN    = 2'b00,
    HM_DELAYED = 2'b01,
    HM_ALT     = 2'b10,
    HM_SPARE   = 2'b11
  } hmode_t;

  // Alternate mode is the only mode that accepts toggle events.
  function automatic logic mode_is_alt(input logic [1:0] m);
    return m == HM_ALT;
  endfunction

  // Next select value. 1 selects the delayed sweep.
  function automatic logic next_select(input logic [1:0] m,
                                       input logic       was_alt,
                                       input logic       cur,
                                       input logic       evt);
    logic r;
    case (m)
      HM_DELAYED: r = 1'b1;
      HM_ALT:     r = was_alt ? (cur ^ evt) : 1'b0;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // Active-low separation: only in alternate mode while the delayed sweep shows.
  function automatic logic sep_level(input logic sel, input logic in_alt);
    return ~(sel & in_alt);
  endfunction

endpackage

// File: rtl/sweep_edge_sync.sv
module sweep_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], async_i};
      prev_q <= pipe_q[LAST];
    end
  end

  assign fall_o = prev_q & ~pipe_q[LAST];

  // R8: a detected edge lasts a single cycle
  p_fall_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/sweep_toggle_mux.sv
module sweep_toggle_mux (
  input  logic clk,
  input  logic rst,
  input  logic vert_alt,
  input  logic alt_fall,
  input  logic ch1_fall,
  output logic toggle_evt
);
  // Toggle on a rising edge of the inverted channel-1 signal when vertical alternates.
  assign toggle_evt = vert_alt ? ch1_fall : alt_fall;

  // R3: with vert_alt low, only alt-sync edges qualify
  p_src_altsync_r3: assert property (@(posedge clk) disable iff (rst)
    (!vert_alt && !alt_fall) |-> !toggle_evt);
  // R4: with vert_alt high, only channel-1 edges qualify
  p_src_ch1_r4: assert property (@(posedge clk) disable iff (rst)
    (vert_alt && !ch1_fall) |-> !toggle_evt);

endmodule

// File: rtl/sweep_sel_reg.sv
module sweep_sel_reg
  import alt_sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] hmode,
  input  logic       toggle_evt,
  output logic       dly_sel,
  output logic       sep_n
);
  logic alt_q;
  logic sel_d;
  logic alt_d;

  assign alt_d = mode_is_alt(hmode);
  assign sel_d = next_select(hmode, alt_q, dly_sel, toggle_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_sel <= 1'b0;
      alt_q   <= 1'b0;
      sep_n   <= 1'b1;
    end else begin
      dly_sel <= sel_d;
      alt_q   <= alt_d;
      sep_n   <= sep_level(sel_d, alt_d);
    end
  end

  // R1: main-only (and spare code) forces the main sweep
  p_main_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (hmode == HM_MAIN || hmode == HM_SPARE) |=> (!dly_sel && sep_n));
  // R2: delayed-only forces the delayed sweep without separation
  p_dly_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hmode == HM_DELAYED) |=> (dly_sel && sep_n));
  // R3/R4: a qualified event inside alternate mode inverts the select
  p_toggle_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (alt_q && hmode == HM_ALT && toggle_evt) |=> (dly_sel != $past(dly_sel)));
  // R9: no event, no change while alternating
  p_toggle_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (alt_q && hmode == HM_ALT && !toggle_evt) |=> $stable(dly_sel));
  // R5: entry into alternate starts on the main sweep
  p_alt_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (!alt_q && hmode == HM_ALT) |=> !dly_sel);
  // R6: separation tracks select and mode registers
  p_sep_track_r6: assert property (@(posedge clk) disable iff (rst)
    sep_n == !(dly_sel && alt_q));
  // R7: reset clears to main, separation off
  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (!dly_sel && sep_n));

endmodule

// File: rtl/alt_sweep_selector.sv
module alt_sweep_selector #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] hmode,
  input  logic       vert_alt,
  input  logic       alt_sync,
  input  logic       ch1_sel,
  output logic       dly_sel,
  output logic       sep_n
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] strobe_in;
  logic [NSRC-1:0] strobe_fall;
  logic            toggle_evt;

  assign strobe_in = {ch1_sel, alt_sync};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    sweep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (strobe_in[g]),
      .fall_o  (strobe_fall[g])
    );
  end

  sweep_toggle_mux u_mux (
    .clk        (clk),
    .rst        (rst),
    .vert_alt   (vert_alt),
    .alt_fall   (strobe_fall[0]),
    .ch1_fall   (strobe_fall[1]),
    .toggle_evt (toggle_evt)
  );

  sweep_sel_reg u_sel (
    .clk        (clk),
    .rst        (rst),
    .hmode      (hmode),
    .toggle_evt (toggle_evt),
    .dly_sel    (dly_sel),
    .sep_n      (sep_n)
  );

endmodule

// File: tb/sim_alt_sweep_selector.sv
module sim_alt_sweep_selector;
  localparam int CLK_P = 10;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] hmode = 2'b00;
  logic       vert_alt = 1'b0;
  logic       alt_sync = 1'b1;
  logic       ch1_sel = 1'b1;
  logic       dly_sel;
  logic       sep_n;

  int checks = 0;
  int errors = 0;
  logic       m_sel = 1'b0;
  logic [1:0] m_mode = 2'b00;

  always #(CLK_P/2) clk = ~clk;

  alt_sweep_selector u0 (
    .clk(clk), .rst(rst), .hmode(hmode), .vert_alt(vert_alt),
    .alt_sync(alt_sync), .ch1_sel(ch1_sel), .dly_sel(dly_sel), .sep_n(sep_n)
  );

  function automatic logic exp_sep(input logic s, input logic [1:0] m);
    return !(s && m == 2'b10);
  endfunction

  function automatic logic mode_sel(input logic [1:0] nm, input logic [1:0] om,
                                    input logic cur);
    if (nm == 2'b01) return 1'b1;
    if (nm == 2'b10) return (om == 2'b10) ? cur : 1'b0;
    return 1'b0;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic es, input logic ep);
    checks++;
    if (dly_sel !== es || sep_n !== ep) begin
      errors++;
      $display("FAIL %s: dly_sel=%b sep_n=%b expected dly_sel=%b sep_n=%b",
               req, dly_sel, sep_n, es, ep);
    end
  endtask

  task automatic set_mode(input logic [1:0] nm, input string req);
    hmode = nm;
    wait_n(1);
    m_sel = mode_sel(nm, m_mode, m_sel);
    m_mode = nm;
    check(req, m_sel, exp_sep(m_sel, m_mode));
    wait_n(SETTLE);
    check(req, m_sel, exp_sep(m_sel, m_mode));
  endtask

  task automatic pulse_alt(input string req);
    alt_sync = 1'b0;
    wait_n(SETTLE);
    if (m_mode == 2'b10 && !vert_alt) m_sel = ~m_sel;
    check(req, m_sel, exp_sep(m_sel, m_mode));
    alt_sync = 1'b1;
    wait_n(SETTLE);
    check({req, " rise"}, m_sel, exp_sep(m_sel, m_mode));
  endtask

  task automatic pulse_ch1(input string req);
    ch1_sel = 1'b0;
    wait_n(SETTLE);
    if (m_mode == 2'b10 && vert_alt) m_sel = ~m_sel;
    check(req, m_sel, exp_sep(m_sel, m_mode));
    ch1_sel = 1'b1;
    wait_n(SETTLE);
    check({req, " rise"}, m_sel, exp_sep(m_sel, m_mode));
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2024);
    wait_n(3);
    check("R7 reset", 1'b0, 1'b1);
    rst = 1'b0;
    wait_n(2);
    check("R1 idle main", 1'b0, 1'b1);

    set_mode(2'b01, "R2 delayed");
    pulse_alt("R9 alt_sync in delayed");
    pulse_ch1("R9 ch1 in delayed");
    set_mode(2'b00, "R1 main");
    pulse_alt("R9 alt_sync in main");
    set_mode(2'b01, "R2 delayed again");
    set_mode(2'b10, "R5 entry from delayed");
    pulse_alt("R3 first toggle");
    pulse_alt("R3 second toggle");
    pulse_ch1("R3 ch1 ignored");
    vert_alt = 1'b1;
    wait_n(SETTLE);
    check("R4 vert_alt switch no change", m_sel, exp_sep(m_sel, m_mode));
    pulse_alt("R4 alt_sync ignored");
    pulse_ch1("R4 ch1 toggle");
    pulse_ch1("R4 ch1 toggle back");

    // R8: latency of exactly two edges after the input fall
    vert_alt = 1'b0;
    wait_n(SETTLE);
    alt_sync = 1'b0;
    wait_n(2);
    check("R8 not yet", m_sel, exp_sep(m_sel, m_mode));
    wait_n(1);
    m_sel = ~m_sel;
    check("R8 toggled", m_sel, exp_sep(m_sel, m_mode));
    alt_sync = 1'b1;
    wait_n(SETTLE);
    check("R6 sep after toggle", m_sel, exp_sep(m_sel, m_mode));

    set_mode(2'b11, "R1 spare code");
    set_mode(2'b10, "R5 entry from spare");

    for (int i = 0; i < 300; i++) begin
      case ($urandom % 5)
        0: set_mode(2'($urandom % 4), "R1 R2 R5 random mode");
        1, 2: pulse_alt("R3 R6 random alt_sync");
        3: pulse_ch1("R4 R6 random ch1");
        default: begin
          vert_alt = ~vert_alt;
          wait_n(SETTLE);
          check("R4 random vert_alt", m_sel, exp_sep(m_sel, m_mode));
        end
      endcase
    end

    rst = 1'b1;
    wait_n(1);
    m_sel = 1'b0;
    m_mode = 2'b00;
    check("R7 late reset", 1'b0, 1'b1);
    rst = 1'b0;
    hmode = 2'b00;
    wait_n(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule